// File: doc/BRIEF.md
# Wake Output Combiner and Controller

This block merges the pattern-match pulses of three receiver channels into a single active-low wake pin. It runs on the low-frequency receiver clock. A wake comes from one of four sources: a match on any enabled channel, a pair of matches close together in double-pattern mode, the end of the power-on interval, or the overflow of a free-running timer. Once the pin is low it stays low until software clears it. Software does this by raising a clear bit and then lowering it again.

A test multiplexer can replace the normal pin level. It can show the raw data stream of one chosen channel, or that channel's own latched wake indication. Each channel's wake indication is held until the next clear, so a host can find out afterwards which channel caused a wake.

Top module: `wake_combiner`

## Requirements
- R1: In single mode (`dbl_mode`=0), after the power-on interval and with `wake_clr` low, a pulse on `ch_match[i]` with `ch_en[i]`=1 drives `wake_n` low from the next clock edge onward. All channels are ORed, and `wake_n` stays low until cleared.
- R2: A match pulse on a channel whose `ch_en` bit is 0 causes no wake and sets no per-channel indication.
- R3: In double mode (`dbl_mode`=1), a lone match causes no wake. A second enabled match, from the same channel or any other, that arrives while fewer than `WIN_SLOTS` `half_bit_stb` strobes have occurred since the first match drives `wake_n` low at the next edge.
- R4: In double mode, a match that arrives after `WIN_SLOTS` strobes have elapsed since the first match causes no wake. It becomes the new first match. Matches in the same cycle count as one.
- R5: After reset is released, `wake_n` is high for the first `POR_CYCLES`-1 clock edges. It goes low at edge `POR_CYCLES`, which is the power-on wake. Matches and timer overflows during this interval are ignored.
- R6: While `wake_clr` is 1, `wake_n` (outside test mode) is high at once, and every wake source is blocked. After `wake_clr` returns to 0, detection works again.
- R7: With `timer_en`=1, a `TIMER_BITS`-bit counter advances every cycle. The cycle in which it wraps from all ones sets a wake. Clearing the wake does not reset the counter.
- R8: With `test_en`=1 and `test_sel`=0, `wake_n` shows `ch_data` of the channel chosen by `ch_sel`. Value 0 selects channel 1 (bit 0), 1 selects channel 2, and 2 selects channel 3. `ch_sel`=3 gives a high pin.
- R9: With `test_en`=1 and `test_sel`=1, `wake_n` shows the inverse of the chosen channel's latched wake indication. That indication is kept until `wake_clr`. `test_sel` values 2 and 3 give a high pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_data | input | 3 | Raw data stream per channel |
| ch_match | input | 3 | One-cycle pattern-match pulse per channel |
| ch_en | input | 3 | Channel enable bits |
| half_bit_stb | input | 1 | One pulse per half-bit slot |
| dbl_mode | input | 1 | 1 = two matches are needed for a wake |
| wake_clr | input | 1 | Clear and hold; wake is re-armed when it returns to 0 |
| timer_en | input | 1 | Enables the periodic artificial wake timer |
| test_en | input | 1 | Routes the test multiplexer to the pin |
| test_sel | input | 2 | 0 = channel data, 1 = channel wake, else high |
| ch_sel | input | 2 | Channel chosen for the test multiplexer |
| wake_n | output | 1 | Active-low wake pin |

## Verification
Single mode is driven with matches on disabled and enabled channels, to show whether the enable mask is applied before the OR. Double mode receives a lone match, a cross-channel pair inside the window, and a pair split by a full window of strobes. These cases separate a window that ends at the correct strobe count from one that is off by one, and a re-armed late match from one that is dropped. Timer wakes are placed on both sides of a long clear, which exposes a counter that the clear resets. Randomised phases mix clears, strobes, mode changes and test selections against a cycle model.

// File: rtl/wake_combiner.sv
module wake_combiner #(
  parameter int POR_CYCLES = 164,
  parameter int TIMER_BITS = 28,
  parameter int WIN_SLOTS  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] ch_data,
  input  logic [2:0] ch_match,
  input  logic [2:0] ch_en,
  input  logic       half_bit_stb,
  input  logic       dbl_mode,
  input  logic       wake_clr,
  input  logic       timer_en,
  input  logic       test_en,
  input  logic [1:0] test_sel,
  input  logic [1:0] ch_sel,
  output logic       wake_n
);
  localparam int PW = $clog2(POR_CYCLES + 1);
  localparam int CW = $clog2(WIN_SLOTS + 1);

  logic [PW-1:0]         por_cnt;
  logic [TIMER_BITS-1:0] tmr;
  logic [CW-1:0]         win_cnt;
  logic [2:0]            chw_q;
  logic [2:0]            hit;
  logic wake_q, armed, por_done, tmr_ovf, live, in_win, det;
  logic sel_data, sel_wake, tst_n;

  assign por_done = (por_cnt == PW'(POR_CYCLES));
  assign tmr_ovf  = timer_en & (&tmr);
  assign hit      = ch_match & ch_en;
  assign live     = por_done & ~wake_clr;
  assign in_win   = armed & (win_cnt < CW'(WIN_SLOTS));
  assign det      = (|hit) & (~dbl_mode | in_win);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         por_cnt <= '0;
    else if (!por_done) por_cnt <= por_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        tmr <= '0;
    else if (timer_en) tmr <= tmr + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed   <= 1'b0;
      win_cnt <= '0;
    end else if (!live || !dbl_mode) begin
      armed   <= 1'b0;
      win_cnt <= '0;
    end else if (|hit) begin
      armed   <= ~in_win;
      win_cnt <= '0;
    end else if (half_bit_stb && in_win) begin
      win_cnt <= win_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                      wake_q <= 1'b0;
    else if (wake_clr)                               wake_q <= 1'b0;
    else if (!por_done && por_cnt == PW'(POR_CYCLES - 1)) wake_q <= 1'b1;
    else if (live && (det || tmr_ovf))               wake_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        chw_q <= '0;
    else if (wake_clr) chw_q <= '0;
    else if (live)     chw_q <= chw_q | hit;

  always_comb begin
    sel_data = 1'b1;
    sel_wake = 1'b0;
    case (ch_sel)
      2'd0: begin sel_data = ch_data[0]; sel_wake = chw_q[0]; end
      2'd1: begin sel_data = ch_data[1]; sel_wake = chw_q[1]; end
      2'd2: begin sel_data = ch_data[2]; sel_wake = chw_q[2]; end
      default: ;
    endcase
    case (test_sel)
      2'd0:    tst_n = sel_data;
      2'd1:    tst_n = ~sel_wake;
      default: tst_n = 1'b1;
    endcase
  end

  assign wake_n = test_en ? tst_n : (~wake_q | wake_clr);
endmodule

// File: rtl/wake_combiner_chk.sv
module wake_combiner_chk #(
  parameter int WIN_SLOTS = 16,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wake_n,
  input logic          wake_clr,
  input logic          test_en,
  input logic          dbl_mode,
  input logic          por_done,
  input logic          tmr_ovf,
  input logic [2:0]    hit,
  input logic [2:0]    chw_q,
  input logic [CW-1:0] win_cnt
);
  p_single_wake_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (por_done && !wake_clr && !dbl_mode && |hit) |=> (wake_clr || test_en || !wake_n));

  p_win_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt <= CW'(WIN_SLOTS));

  p_por_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_done && !test_en) |-> wake_n);

  p_clr_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_clr && !test_en) |-> wake_n);

  p_timer_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (por_done && !wake_clr && tmr_ovf) |=> (wake_clr || test_en || !wake_n));

  p_chw_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_clr |=> ((chw_q & $past(chw_q)) == $past(chw_q)));
endmodule

bind wake_combiner wake_combiner_chk #(.WIN_SLOTS(WIN_SLOTS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wake_n(wake_n), .wake_clr(wake_clr),
  .test_en(test_en), .dbl_mode(dbl_mode), .por_done(por_done),
  .tmr_ovf(tmr_ovf), .hit(hit), .chw_q(chw_q), .win_cnt(win_cnt)
);

// File: tb/wake_combiner_tb.sv
`timescale 1ns/1ps
module wake_combiner_tb;
  localparam int POR = 20;
  localparam int TB  = 8;
  localparam int WIN = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] ch_data = '0, ch_match = '0, ch_en = '0;
  logic stb = 0, dbl = 0, clr = 0, tmr_en = 0, test_en = 0;
  logic [1:0] test_sel = '0, ch_sel = '0;
  logic wake_n;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wake_combiner #(.POR_CYCLES(POR), .TIMER_BITS(TB), .WIN_SLOTS(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .ch_data(ch_data), .ch_match(ch_match), .ch_en(ch_en),
    .half_bit_stb(stb), .dbl_mode(dbl), .wake_clr(clr), .timer_en(tmr_en),
    .test_en(test_en), .test_sel(test_sel), .ch_sel(ch_sel), .wake_n(wake_n));

  int m_por, m_tmr, m_cnt;
  bit m_wake, m_arm;
  logic [2:0] m_chw;

  always @(posedge clk) begin
    logic [2:0] h;
    bit ovf, pdone;
    if (!rst_n) begin
      m_por = 0; m_tmr = 0; m_cnt = 0; m_wake = 0; m_arm = 0; m_chw = '0;
    end else begin
      ovf = tmr_en && (m_tmr == (1 << TB) - 1);
      if (tmr_en) m_tmr = (m_tmr + 1) % (1 << TB);
      pdone = (m_por == POR);
      h = ch_match & ch_en;
      if (!pdone) m_por++;
      if (clr) begin
        m_wake = 0; m_chw = '0; m_arm = 0; m_cnt = 0;
      end else if (!pdone) begin
        if (m_por == POR) m_wake = 1;
      end else begin
        m_chw |= h;
        if (!dbl) begin
          m_arm = 0; m_cnt = 0;
          if (|h) m_wake = 1;
        end else if (|h) begin
          if (m_arm && m_cnt < WIN) begin m_wake = 1; m_arm = 0; end
          else begin m_arm = 1; m_cnt = 0; end
        end else if (stb && m_arm && m_cnt < WIN) m_cnt++;
        if (ovf) m_wake = 1;
      end
    end
  end

  function automatic logic exp_pin();
    logic d, w;
    d = (ch_sel == 2'd3) ? 1'b1 : ch_data[ch_sel];
    w = (ch_sel == 2'd3) ? 1'b0 : m_chw[ch_sel];
    if (!test_en) return ~m_wake | clr;
    if (test_sel == 2'd0) return d;
    if (test_sel == 2'd1) return ~w;
    return 1'b1;
  endfunction

  task automatic chk(input string tag, input logic exp);
    n_chk++;
    if (wake_n !== exp) begin
      n_fail++;
      $display("FAIL %s: wake_n got %b expected %b at %0t", tag, wake_n, exp, $time);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(posedge clk); @(negedge clk);
      if (rst_n) chk(test_en ? "R8/R9 model" : "R1/R3 model", exp_pin());
    end
  endtask

  task automatic pulse(input logic [2:0] m);
    ch_match = m; tick(); ch_match = '0;
  endtask

  task automatic clear();
    clr = 1; tick(); clr = 0; tick();
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    chk("R5 reset state", 1'b1);
    tick(POR - 1);
    chk("R5 high through interval", 1'b1);
    tick();
    chk("R5 power-on wake", 1'b0);

    clr = 1; tick();
    chk("R6 clear forces high", 1'b1);
    ch_en = 3'b111; pulse(3'b111);
    chk("R6 match blocked while clear held", 1'b1);
    clr = 0; tick();
    chk("R6 released, no source", 1'b1);

    ch_en = 3'b101; pulse(3'b010);
    chk("R2 disabled channel ignored", 1'b1);
    pulse(3'b100);
    chk("R1 enabled channel wakes", 1'b0);

    test_en = 1; test_sel = 2'd1; ch_sel = 2'd2; #1;
    chk("R9 channel 3 wake shown", 1'b0);
    ch_sel = 2'd0; #1;
    chk("R9 channel 1 not latched", 1'b1);
    test_sel = 2'd2; #1;
    chk("R9 unused select high", 1'b1);
    test_sel = 2'd0; ch_data = 3'b010; ch_sel = 2'd1; #1;
    chk("R8 channel 2 data", 1'b1);
    ch_sel = 2'd0; #1;
    chk("R8 channel 1 data", 1'b0);
    ch_sel = 2'd3; #1;
    chk("R8 unused channel select high", 1'b1);
    test_en = 0; #1;
    chk("R1 wake still held", 1'b0);
    clear();
    chk("R6 cleared", 1'b1);

    dbl = 1; ch_en = 3'b111;
    pulse(3'b001);
    stb = 1; tick(3); stb = 0;
    chk("R3 lone match no wake", 1'b1);
    pulse(3'b100);
    chk("R3 cross-channel pair wakes", 1'b0);
    clear();

    pulse(3'b010);
    stb = 1; tick(WIN); stb = 0;
    pulse(3'b001);
    chk("R4 late match no wake", 1'b1);
    pulse(3'b001);
    chk("R4 late match restarted window", 1'b0);
    clear();
    pulse(3'b010);
    stb = 1; tick(WIN - 1); stb = 0;
    pulse(3'b100);
    chk("R3 match at last window slot wakes", 1'b0);
    clear();
    dbl = 0;

    tmr_en = 1;
    tick((1 << TB) - 1);
    chk("R7 no wake before wrap", 1'b1);
    tick();
    chk("R7 wrap wakes", 1'b0);
    clr = 1; tick(100); clr = 0;
    tick((1 << TB) - 101);
    chk("R7 counter not reset by clear", 1'b1);
    tick();
    chk("R7 second wrap wakes", 1'b0);
    tmr_en = 0;
    clear();

    for (int i = 0; i < 4000; i++) begin
      if (i % 250 == 0) begin
        dbl = 1'($urandom % 2); ch_en = 3'($urandom); tmr_en = 1'($urandom % 2);
        test_en = ($urandom % 6 == 0); test_sel = 2'($urandom); ch_sel = 2'($urandom);
      end
      for (int b = 0; b < 3; b++) ch_match[b] = ($urandom % 12 == 0);
      stb = ($urandom % 3 == 0);
      ch_data = 3'($urandom);
      if (clr) clr = ($urandom % 4 != 0);
      else     clr = ($urandom % 60 == 0);
      tick();
    end

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule